// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace samples into an on-chip circular RAM so that a debugger can later recover the history around an event of interest. While capture is enabled, every cycle with a valid sample stores one frame at the write pointer, which then steps forward and wraps at the end of the RAM. Once a wrap has happened, the buffer keeps the most recent DEPTH frames.

A trigger input marks the event. After the trigger, the block stores a programmable number of further frames and then stops. A short drain interval models the output path of the trace formatter. Acquisition-complete is reported only when that interval has ended.

Software reaches the buffer through a flat register bus with an address, write data, a write strobe and a read strobe. The bus exposes fixed identification and geometry words, a status word, a RAM data window that steps through the frames, both pointers, the post-trigger count and a control word. Read data is registered and appears one cycle after the read strobe.

Top module: `trace_capture_buf`

## Requirements
- R1: Registers sit at fixed addresses: 0 identification (ID_VALUE), 1 RAM depth (DEPTH), 2 frame width (FRAME_W), 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 post-trigger count, 8 control. Addresses 0 to 3 are read-only, and writes to them have no effect. Other addresses read 0.
- R2: While control bit 0 is 1 and acquisition has not stopped, each cycle with trc_valid high stores trc_data at the write pointer and advances the pointer, going from DEPTH-1 back to 0. While control bit 0 is 0, nothing is stored and the write pointer holds.
- R3: Status bit 0 (wrapped) becomes 1 when a frame is stored at address DEPTH-1. It stays set until software writes the write pointer register, and that write clears it.
- R4: Status bit 1 (triggered) becomes 1 in the cycle after trc_trigger is high while capture is active. A trigger while capture is disabled is ignored.
- R5: After the frame stored with the trigger, exactly N more valid frames are stored, where N is the post-trigger count. The count decreases by one for each such frame and then holds at 0. Once it reaches 0, no further frames are stored.
- R6: When acquisition stops, status bit 3 (formatter empty) is 0 for exactly two cycles. Status bit 2 (acquisition complete) rises in the same cycle that bit 3 returns to 1.
- R7: A read of the RAM data register returns the frame at the read pointer and advances the read pointer by one, wrapping from DEPTH-1 to 0. reg_rdata holds the value in the cycle after reg_rd.
- R8: The read and write pointers are software-writable. Writing control with bit 0 = 1 while it was 0 clears the triggered, stopped, complete and drain state.
- R9: Control bit 1 (demultiplexed mode) can be stored only when PORT_W is 8. With any other PORT_W it always reads 0.
- R10: After reset, status reads 0x8, both pointers and the count read 0, and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | Trace sample valid this cycle |
| trc_data | input | FRAME_W | Trace sample |
| trc_trigger | input | 1 | Trigger event |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
The hardest situation to observe is the two-cycle drain window. It lies between the stop and the rise of acquisition-complete, and it is visible only through a registered status read. The bench holds the read strobe on the status address through the trigger cycle and the following cycles. This yields one status snapshot per cycle, and the bench compares each snapshot with the sequence it expects. The post-trigger stop point is swept over several counts and trigger positions. Wrap recovery is checked by reading the whole buffer from the write pointer, with the read pointer crossing the top of the RAM.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [3:0] {
        RA_IDENT  = 4'd0,
        RA_DEPTH  = 4'd1,
        RA_WIDTH  = 4'd2,
        RA_STATUS = 4'd3,
        RA_DATA   = 4'd4,
        RA_RDPTR  = 4'd5,
        RA_WRPTR  = 4'd6,
        RA_TRGCNT = 4'd7,
        RA_CTRL   = 4'd8
    } reg_addr_e;

    // bit 3 .. bit 0 of the status word
    typedef struct packed {
        logic drain_empty;
        logic acq_done;
        logic trig_seen;
        logic wrapped;
    } status_t;

    localparam int unsigned DRAIN_CYCLES = 2;

    function automatic logic [31:0] wrap_inc(logic [31:0] p, int unsigned depth);
        return (p == 32'(depth - 1)) ? 32'd0 : p + 32'd1;
    endfunction

endpackage

// File: rtl/tcb_store.sv
module tcb_store #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned FRAME_W = 32,
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_addr,
    output logic [FRAME_W-1:0] rd_data
);
    logic [FRAME_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             arm,
    input  logic             trc_valid,
    input  logic             trc_trigger,
    input  logic             wptr_load,
    input  logic             cnt_load,
    input  logic [31:0]      load_value,
    output logic             wr_en,
    output logic [PTR_W-1:0] wptr,
    output logic [31:0]      count,
    output status_t          status
);
    logic       wrapped, trig_seen, stopped, acq_done;
    logic [1:0] drain;
    logic       capturing;

    assign capturing = enable && !stopped && !(trig_seen && count == 32'd0);
    assign wr_en     = capturing && trc_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            wrapped   <= 1'b0;
            trig_seen <= 1'b0;
            stopped   <= 1'b0;
            acq_done  <= 1'b0;
            drain     <= '0;
            count     <= '0;
        end else begin
            if (wptr_load)  wptr <= load_value[PTR_W-1:0];
            else if (wr_en) wptr <= PTR_W'(wrap_inc(32'(wptr), DEPTH));

            if (wptr_load) wrapped <= 1'b0;
            else if (wr_en && wptr == PTR_W'(DEPTH - 1)) wrapped <= 1'b1;

            if (arm) begin
                trig_seen <= 1'b0;
                stopped   <= 1'b0;
                acq_done  <= 1'b0;
                drain     <= '0;
            end else begin
                if (capturing && trc_trigger) trig_seen <= 1'b1;
                if (enable && trig_seen && count == 32'd0 && !stopped) begin
                    stopped <= 1'b1;
                    drain   <= 2'(DRAIN_CYCLES);
                end else if (drain != 2'd0) begin
                    drain <= drain - 2'd1;
                end
                if (stopped && drain == 2'd1) acq_done <= 1'b1;
            end

            if (cnt_load) count <= load_value;
            else if (wr_en && trig_seen && count != 32'd0) count <= count - 32'd1;
        end
    end

    assign status = '{drain_empty: (drain == 2'd0), acq_done: acq_done,
                      trig_seen: trig_seen, wrapped: wrapped};

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wptr_load |=> wptr == PTR_W'(wrap_inc(32'($past(wptr)), DEPTH))); // R2
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        wrapped && !wptr_load |=> wrapped); // R3
    AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (rst)
        trig_seen && !arm |=> trig_seen); // R4
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        count == 32'd0 && !cnt_load |=> count == 32'd0); // R5
    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_done) |-> $past(stopped, 2)); // R6
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned FRAME_W  = 32,
    parameter int unsigned PORT_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h5443_0100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trc_valid,
    input  logic [FRAME_W-1:0] trc_data,
    input  logic               trc_trigger,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_wr,
    input  logic               reg_rd,
    output logic [31:0]        reg_rdata
);
    localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit          DEMUX_OK = (PORT_W == 8);

    reg_addr_e          addr_e;
    logic               ctrl_wr, ctrl_en, demux_q, arm;
    logic               rptr_load, data_read;
    logic [PTR_W-1:0]   rptr, wptr;
    logic               wr_en;
    logic [31:0]        count;
    status_t            status;
    logic [FRAME_W-1:0] rd_frame;

    assign addr_e    = reg_addr_e'(reg_addr);
    assign ctrl_wr   = reg_wr && addr_e == RA_CTRL;
    assign arm       = ctrl_wr && reg_wdata[0] && !ctrl_en;
    assign rptr_load = reg_wr && addr_e == RA_RDPTR;
    assign data_read = reg_rd && addr_e == RA_DATA;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_en <= 1'b0;
        else if (ctrl_wr) ctrl_en <= reg_wdata[0];
    end

    if (DEMUX_OK) begin : g_demux
        always_ff @(posedge clk) begin
            if (rst)          demux_q <= 1'b0;
            else if (ctrl_wr) demux_q <= reg_wdata[1];
        end
    end else begin : g_nodemux
        assign demux_q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)            rptr <= '0;
        else if (rptr_load) rptr <= reg_wdata[PTR_W-1:0];
        else if (data_read) rptr <= PTR_W'(wrap_inc(32'(rptr), DEPTH));
    end

    tcb_acq #(.DEPTH(DEPTH)) acq_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (ctrl_en),
        .arm        (arm),
        .trc_valid  (trc_valid),
        .trc_trigger(trc_trigger),
        .wptr_load  (reg_wr && addr_e == RA_WRPTR),
        .cnt_load   (reg_wr && addr_e == RA_TRGCNT),
        .load_value (reg_wdata),
        .wr_en      (wr_en),
        .wptr       (wptr),
        .count      (count),
        .status     (status)
    );

    tcb_store #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) store_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wptr),
        .wr_data(trc_data),
        .rd_addr(rptr),
        .rd_data(rd_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (addr_e)
                RA_IDENT:  reg_rdata <= ID_VALUE;
                RA_DEPTH:  reg_rdata <= 32'(DEPTH);
                RA_WIDTH:  reg_rdata <= 32'(FRAME_W);
                RA_STATUS: reg_rdata <= {28'd0, status};
                RA_DATA:   reg_rdata <= 32'(rd_frame);
                RA_RDPTR:  reg_rdata <= 32'(rptr);
                RA_WRPTR:  reg_rdata <= 32'(wptr);
                RA_TRGCNT: reg_rdata <= count;
                RA_CTRL:   reg_rdata <= {30'd0, demux_q, ctrl_en};
                default:   reg_rdata <= '0;
            endcase
        end
    end

    AST_RPTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        data_read && !rptr_load |=> rptr == PTR_W'(wrap_inc(32'($past(rptr)), DEPTH))); // R7
    AST_DEPTH_CONST: assert property (@(posedge clk) disable iff (rst)
        reg_rd && addr_e == RA_DEPTH |=> reg_rdata == 32'(DEPTH)); // R1
    AST_NO_WRITE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> !wr_en); // R2
endmodule

// File: tb/trace_capture_buf_tb_top.sv
module trace_capture_buf_tb_top;
    localparam int DEPTH = 16;
    localparam int FW    = 32;
    localparam logic [31:0] IDV = 32'h5443_0100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trc_valid = 1'b0;
    logic [FW-1:0] trc_data = '0;
    logic          trc_trigger = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   rdata, rdata4;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEPTH), .FRAME_W(FW), .PORT_W(8), .ID_VALUE(IDV)) dut_i (
        .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data),
        .trc_trigger(trc_trigger), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(rdata));

    trace_capture_buf #(.DEPTH(DEPTH), .FRAME_W(FW), .PORT_W(4), .ID_VALUE(IDV)) dut4_i (
        .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_data(trc_data),
        .trc_trigger(trc_trigger), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(rdata4));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        v = rdata;
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [31:0] d, input logic t);
        @(negedge clk);
        trc_valid = 1'b1; trc_data = d; trc_trigger = t;
    endtask

    task automatic idle();
        @(negedge clk);
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    task automatic rearm(input logic [31:0] cnt);
        reg_write(4'd8, 32'd0);
        reg_write(4'd6, 32'd0);
        reg_write(4'd7, cnt);
        reg_write(4'd8, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s [5];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        reg_read(4'd3, v); check("R10 status", v, 32'h8);
        reg_read(4'd5, v); check("R10 rptr", v, 0);
        reg_read(4'd6, v); check("R10 wptr", v, 0);
        reg_read(4'd7, v); check("R10 count", v, 0);
        reg_read(4'd8, v); check("R10 ctrl", v, 0);

        // R1 constants and ignored writes
        reg_write(4'd0, 32'hFFFF_FFFF); reg_write(4'd1, 32'hFFFF_FFFF);
        reg_write(4'd2, 32'hFFFF_FFFF); reg_write(4'd3, 32'hFFFF_FFFF);
        reg_read(4'd0, v); check("R1 ident", v, IDV);
        reg_read(4'd1, v); check("R1 depth", v, DEPTH);
        reg_read(4'd2, v); check("R1 width", v, FW);
        reg_read(4'd3, v); check("R1 status ro", v, 32'h8);
        reg_read(4'd12, v); check("R1 unmapped", v, 0);

        // R2 and R4: disabled capture stores nothing, ignores trigger
        push(32'hDEAD_0001, 1'b1); push(32'hDEAD_0002, 1'b0); push(32'hDEAD_0003, 1'b1);
        idle();
        reg_read(4'd6, v); check("R2 disabled wptr", v, 0);
        reg_read(4'd3, v); check("R4 disabled trigger", v, 32'h8);

        // R9 demux bit
        reg_write(4'd8, 32'h2);
        reg_read(4'd8, v);
        check("R9 demux port8", v, 32'h2);
        check("R9 demux port4", rdata4, 32'h0);
        reg_write(4'd8, 32'h0);

        // R2 R7: no-wrap sweep over fill levels
        for (int n = 1; n < DEPTH; n++) begin
            rearm(32'd0);
            for (int i = 0; i < n; i++) push(32'h2000_0000 + n * 256 + i, 1'b0);
            idle();
            reg_read(4'd6, v); check("R2 fill wptr", v, n);
            reg_read(4'd3, v); check("R3 no wrap", v, 32'h8);
            reg_write(4'd5, 32'd0);
            for (int i = 0; i < n; i++) begin
                reg_read(4'd4, v); check("R7 frame", v, 32'h2000_0000 + n * 256 + i);
            end
            reg_read(4'd5, v); check("R7 rptr after reads", v, n);
        end

        // R3 R7 R8: wrap, recover oldest-first from write pointer
        rearm(32'd0);
        for (int i = 0; i < DEPTH + 5; i++) push(32'h1000 + i, 1'b0);
        idle();
        reg_read(4'd6, v); check("R2 wrap wptr", v, 5);
        reg_read(4'd3, v); check("R3 wrapped set", v, 32'h9);
        reg_write(4'd5, 32'd5);
        for (int k = 0; k < DEPTH; k++) begin
            reg_read(4'd4, v); check("R7 wrap order", v, 32'h1000 + 5 + k);
        end
        reg_read(4'd5, v); check("R7 rptr wrapped", v, 5);
        reg_write(4'd8, 32'd0);
        reg_write(4'd6, 32'd3);
        reg_read(4'd3, v); check("R3 cleared by wptr write", v, 32'h8);
        reg_read(4'd6, v); check("R8 wptr load", v, 3);

        // R5: post-trigger count sweep
        for (int cnt = 0; cnt < 5; cnt++) begin
            for (int t = 0; t < 3; t++) begin
                rearm(cnt);
                for (int i = 0; i < t; i++) push(32'h3000 + i, 1'b0);
                push(32'h3000 + t, 1'b1);
                for (int i = t + 1; i < t + 9; i++) push(32'h3000 + i, 1'b0);
                idle();
                reg_read(4'd6, v); check("R5 stop point", v, t + 1 + cnt);
                reg_read(4'd3, v); check("R6 final status", v, 32'hE);
                reg_read(4'd7, v); check("R5 count drained", v, 0);
                reg_write(4'd5, 32'd0);
                for (int i = 0; i < t + 1 + cnt; i++) begin
                    reg_read(4'd4, v); check("R5 frames", v, 32'h3000 + i);
                end
            end
        end

        // R6 R8: per-cycle status across stop and drain
        rearm(32'd0);
        @(negedge clk);
        trc_valid = 1'b1; trc_trigger = 1'b1; trc_data = 32'h4444;
        reg_addr = 4'd3; reg_rd = 1'b1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            s[c] = rdata;
            trc_trigger = 1'b0;
        end
        trc_valid = 1'b0; reg_rd = 1'b0;
        check("R6 cyc0", s[0], 32'h8);
        check("R4 cyc1 triggered", s[1], 32'hA);
        check("R6 cyc2 draining", s[2], 32'h2);
        check("R6 cyc3 draining", s[3], 32'h2);
        check("R6 cyc4 complete", s[4], 32'hE);
        reg_read(4'd6, v); check("R6 single frame", v, 1);
        reg_write(4'd8, 32'd0);
        reg_write(4'd8, 32'd1);
        reg_read(4'd3, v); check("R8 rearm clears", v, 32'h8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule